// File: doc/BRIEF.md
# Open-Row SRAM Access Controller

This block fronts a 4 KB word-addressed static memory organised as four 1 KB banks of 64 rows. Each row is 128 bits wide and carries eight 16-bit words. A 128-bit row latch keeps the most recently touched row together with its bank/row tag. A read that targets the row already in the latch is served straight from the latch. No row is decoded and no word line fires. A read that misses drives one short read word-line pulse, which loads the whole row into the latch.

A write is handled entirely inside one host slot. A read word-line pulse first moves the target row into the latch, with the new 16-bit word merged in. A write word-line pulse then stores the merged row back into the array. Two 2-bit host inputs place the write pulse inside the slot, counted in sub-slot ticks of the block clock. One input sets the gap after the read pulse and the other sets the width of the write pulse. Each host slot is ten ticks long, and `slot_start` marks its first tick. The host presents a command during that tick and sees read results throughout the following slot.

Top module: `ol_sram_ctrl`

## Requirements
- R1: While reset is held, and after its release until the first command, `rvalid`, `rd_from_latch`, `rd_pulse` and `wr_pulse` are 0 and `rdata` is 0. The row latch starts empty, so the first read after reset is a full read.
- R2: The address is split into bank = addr[10:9], row = addr[8:3] and word = addr[2:0]. A read returns the 16-bit word at that position, as last written.
- R3: A read that misses the latched row raises `rd_pulse` for exactly one tick, at slot tick 1. `wr_pulse` stays 0 for the whole slot, and the result reports `rd_from_latch` = 0.
- R4: A read whose bank and row equal the latched tag raises neither pulse during its slot. Its result reports `rd_from_latch` = 1 and carries the stored word.
- R5: After one full read, reads of the other seven words of that row are all low-energy reads.
- R6: A write raises `rd_pulse` at tick 1. `wr_pulse` is then high from tick 2+gap for width+1 ticks, where gap = `gap_ticks` and width = `wr_width`. Only the addressed word of the row changes in the array.
- R7: After a write, the latch holds the merged row. A following read of any word in that row is a low-energy read and returns the newly written data.
- R8: Read results (`rdata`, `rvalid`, `rd_from_latch`) change only at the start of the slot after the read command and stay stable through that slot. A slot with no read command gives `rvalid` = 0 in the next slot.
- R9: When `rd_en` and `wr_en` are both asserted, the write is performed and no read result is produced (`rvalid` = 0).
- R10: `rd_en`, `wr_en`, `addr`, `wdata` and the margin inputs are sampled only during the slot's first tick. Strobes raised at any other tick cause no pulse, no result and no change to memory.
- R11: A slot lasts 10 ticks, with `slot_start` high only on tick 0. Margin values are taken from tick 0, so changing them later in the slot does not move the pulses.
- R12: Rows with the same row index in different banks have distinct tags. A read that changes only the bank is a full read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sub-slot tick clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Read command, sampled on slot tick 0 |
| wr_en | input | 1 | Write command, sampled on slot tick 0 |
| addr | input | 11 | Word address {bank, row, word} |
| wdata | input | 16 | Write data |
| gap_ticks | input | 2 | Ticks between the end of the read pulse and the start of the write pulse |
| wr_width | input | 2 | Write pulse width minus one, in ticks |
| rdata | output | 16 | Read data for the previous slot's read |
| rvalid | output | 1 | Previous slot held a read |
| rd_from_latch | output | 1 | Previous read was served from the latch |
| slot_start | output | 1 | High on tick 0 of each slot |
| rd_pulse | output | 1 | Read word-line pulse |
| wr_pulse | output | 1 | Write word-line pulse |

## Verification
The hardest situations to reach are tag aliasing and latch state that a write leaves behind. These include two banks sharing a row index, a write that replaces the latched row, and a read+write collision. The stimulus builds them deliberately. It fills the same row index in two banks and alternates reads between them. It writes into the row a read has just latched, then reads it back. Strobes are also injected at mid-slot ticks, and a read afterwards shows the memory is untouched. Margins are swept from minimum to maximum and altered mid-slot, so each pulse window can be compared tick by tick against the model.

// File: rtl/ol_pkg.sv
package ol_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_FULL = 2'd1,
    OP_LATCH = 2'd2,
    OP_RMW  = 2'd3
  } op_e;
endpackage

// File: rtl/ol_slot_timer.sv
module ol_slot_timer #(
  parameter int SLOT_TICKS = 10,
  parameter int MARGIN_W   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [MARGIN_W-1:0] gap,
  input  logic [MARGIN_W-1:0] width,
  input  logic                need_rd,
  input  logic                need_wr,
  output logic                first_tick,
  output logic                last_tick,
  output logic                rd_on,
  output logic                wr_on,
  output logic                wr_done
);
  localparam int PH_W = $clog2(SLOT_TICKS);
  localparam int CW   = PH_W + 2;
  localparam logic [PH_W-1:0] LAST = PH_W'(SLOT_TICKS - 1);

  logic [PH_W-1:0] ph_q, ph_d;
  logic [CW-1:0]   wr_first, wr_fin, ph_ext;

  always_comb begin
    if (ph_q == LAST) ph_d = '0;
    else              ph_d = ph_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end

  always_comb begin
    ph_ext   = CW'(ph_q);
    wr_first = CW'(2) + CW'(gap);
    wr_fin   = wr_first + CW'(width);
    first_tick = (ph_q == '0);
    last_tick  = (ph_q == LAST);
    rd_on   = need_rd && (ph_q == PH_W'(1));
    wr_on   = need_wr && (ph_ext >= wr_first) && (ph_ext <= wr_fin);
    wr_done = need_wr && (ph_ext == wr_fin);
  end
endmodule

// File: rtl/ol_row_latch.sv
module ol_row_latch #(
  parameter int WORD_W  = 16,
  parameter int WORDS   = 8,
  parameter int TAG_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load,
  input  logic                       merge,
  input  logic [WORDS*WORD_W-1:0]    row_in,
  input  logic [TAG_W-1:0]           tag_in,
  input  logic [$clog2(WORDS)-1:0]   sel,
  input  logic [WORD_W-1:0]          word_in,
  input  logic [TAG_W-1:0]           probe_tag,
  output logic                       hit,
  output logic [WORD_W-1:0]          word_out,
  output logic [WORDS*WORD_W-1:0]    row_out
);
  localparam int ROW_W = WORDS * WORD_W;

  logic             valid_q;
  logic [TAG_W-1:0] tag_q;
  logic [ROW_W-1:0] data_q, data_d;

  generate
    for (genvar g = 0; g < WORDS; g++) begin : g_merge
      always_comb begin
        if (merge && (sel == g))
          data_d[g*WORD_W +: WORD_W] = word_in;
        else
          data_d[g*WORD_W +: WORD_W] = row_in[g*WORD_W +: WORD_W];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      tag_q   <= '0;
    end else if (load) begin
      valid_q <= 1'b1;
      tag_q   <= tag_in;
    end
  end

  always_ff @(posedge clk) begin
    if (load) data_q <= data_d;
  end

  always_comb begin
    hit      = valid_q && (tag_q == probe_tag);
    word_out = data_q[sel*WORD_W +: WORD_W];
    row_out  = data_q;
  end
endmodule

// File: rtl/ol_cell_array.sv
module ol_cell_array #(
  parameter int ROWS  = 256,
  parameter int ROW_W = 128
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(ROWS)-1:0]  idx,
  input  logic [ROW_W-1:0]         wrow,
  output logic [ROW_W-1:0]         rrow
);
  logic [ROW_W-1:0] cells [ROWS];

  always_ff @(posedge clk) begin
    if (we) cells[idx] <= wrow;
  end

  assign rrow = cells[idx];
endmodule

// File: rtl/ol_sram_ctrl.sv
module ol_sram_ctrl #(
  parameter int ADDR_W     = 11,
  parameter int WORD_W     = 16,
  parameter int WORDS      = 8,
  parameter int BANKS      = 4,
  parameter int SLOT_TICKS = 10,
  parameter int MARGIN_W   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd_en,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [WORD_W-1:0]   wdata,
  input  logic [MARGIN_W-1:0] gap_ticks,
  input  logic [MARGIN_W-1:0] wr_width,
  output logic [WORD_W-1:0]   rdata,
  output logic                rvalid,
  output logic                rd_from_latch,
  output logic                slot_start,
  output logic                rd_pulse,
  output logic                wr_pulse
);
  import ol_pkg::*;

  localparam int SEL_W    = $clog2(WORDS);
  localparam int TAG_W    = ADDR_W - SEL_W;
  localparam int ROWS_ALL = 1 << TAG_W;
  localparam int ROW_W    = WORDS * WORD_W;
  localparam int BANK_W   = $clog2(BANKS);

  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  op_e                 op_q, op_d;
  logic [TAG_W-1:0]    tag_q;
  logic [SEL_W-1:0]    sel_q;
  logic [WORD_W-1:0]   wd_q;
  logic [MARGIN_W-1:0] gap_q, wid_q;
  logic                cmd_en;

  logic first_tick, last_tick, rd_on, wr_on, wr_done;
  logic hit;
  logic [WORD_W-1:0] latch_word;
  logic [ROW_W-1:0]  latch_row, array_row;
  logic [TAG_W-1:0]  probe_tag, use_tag;
  logic [SEL_W-1:0]  use_sel;
  logic [BANK_W-1:0] cmd_bank;

  assign probe_tag = addr[ADDR_W-1:SEL_W];
  assign cmd_bank  = tag_q[TAG_W-1 -: BANK_W];
  assign cmd_en    = first_tick;

  always_comb begin
    if (wr_en)             op_d = OP_RMW;
    else if (rd_en && hit) op_d = OP_LATCH;
    else if (rd_en)        op_d = OP_FULL;
    else                   op_d = OP_IDLE;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      op_q  <= OP_IDLE;
      tag_q <= '0;
      sel_q <= '0;
      wd_q  <= '0;
      gap_q <= '0;
      wid_q <= '0;
    end else if (cmd_en) begin
      op_q  <= op_d;
      tag_q <= probe_tag;
      sel_q <= addr[SEL_W-1:0];
      wd_q  <= wdata;
      gap_q <= gap_ticks;
      wid_q <= wr_width;
    end
  end

  ol_slot_timer #(
    .SLOT_TICKS (SLOT_TICKS),
    .MARGIN_W   (MARGIN_W)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .gap        (gap_q),
    .width      (wid_q),
    .need_rd    ((op_q == OP_FULL) || (op_q == OP_RMW)),
    .need_wr    (op_q == OP_RMW),
    .first_tick (first_tick),
    .last_tick  (last_tick),
    .rd_on      (rd_on),
    .wr_on      (wr_on),
    .wr_done    (wr_done)
  );

  // During tick 0 the latch is probed with the incoming address; afterwards
  // it serves the captured command.
  assign use_tag = first_tick ? probe_tag : tag_q;
  assign use_sel = first_tick ? addr[SEL_W-1:0] : sel_q;

  ol_row_latch #(
    .WORD_W (WORD_W),
    .WORDS  (WORDS),
    .TAG_W  (TAG_W)
  ) u_latch (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .load      (rd_on),
    .merge     (op_q == OP_RMW),
    .row_in    (array_row),
    .tag_in    (tag_q),
    .sel       (use_sel),
    .word_in   (wd_q),
    .probe_tag (use_tag),
    .hit       (hit),
    .word_out  (latch_word),
    .row_out   (latch_row)
  );

  ol_cell_array #(
    .ROWS  (ROWS_ALL),
    .ROW_W (ROW_W)
  ) u_array (
    .clk  (clk),
    .we   (wr_done),
    .idx  (tag_q),
    .wrow (latch_row),
    .rrow (array_row)
  );

  logic [WORD_W-1:0] rdata_d;
  logic              rvalid_d, from_latch_d;

  always_comb begin
    rvalid_d     = (op_q == OP_FULL) || (op_q == OP_LATCH);
    from_latch_d = (op_q == OP_LATCH);
    rdata_d      = rvalid_d ? latch_word : rdata;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rdata         <= '0;
      rvalid        <= 1'b0;
      rd_from_latch <= 1'b0;
    end else if (last_tick) begin
      rdata         <= rdata_d;
      rvalid        <= rvalid_d;
      rd_from_latch <= from_latch_d;
    end
  end

  assign slot_start = first_tick;
  assign rd_pulse   = rd_on;
  assign wr_pulse   = wr_on;

  logic unused_bank;
  assign unused_bank = ^cmd_bank;
endmodule

// File: rtl/ol_sram_ctrl_chk.sv
module ol_sram_ctrl_chk #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_pulse,
  input logic              wr_pulse,
  input logic              slot_start,
  input logic              rvalid,
  input logic              rd_from_latch,
  input logic [WORD_W-1:0] rdata
);
  p_pulses_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_pulse && wr_pulse));

  p_read_pulse_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pulse |=> !rd_pulse);

  p_read_pulse_tick1_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_pulse) |-> $past(slot_start));

  p_latch_flag_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_from_latch |-> rvalid);

  p_write_not_tick0_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |-> !slot_start);

  p_slot_marker_r11: assert property (@(posedge clk) disable iff (!rst_n)
    slot_start |=> !slot_start);

  p_result_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_start |-> ($stable(rdata) && $stable(rvalid) && $stable(rd_from_latch)));
endmodule

bind ol_sram_ctrl ol_sram_ctrl_chk #(.WORD_W(WORD_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_int_n),
  .rd_pulse      (rd_pulse),
  .wr_pulse      (wr_pulse),
  .slot_start    (slot_start),
  .rvalid        (rvalid),
  .rd_from_latch (rd_from_latch),
  .rdata         (rdata)
);

// File: tb/sim_ol_sram_ctrl.sv
module sim_ol_sram_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        rd_en, wr_en;
  logic [10:0] addr;
  logic [15:0] wdata;
  logic [1:0]  gap_ticks, wr_width;
  logic [15:0] rdata;
  logic        rvalid, rd_from_latch, slot_start, rd_pulse, wr_pulse;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [15:0] ref_mem [int];
  bit          ref_valid;
  int          ref_tag;

  always #4 clk = ~clk;

  ol_sram_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .gap_ticks(gap_ticks), .wr_width(wr_width), .rdata(rdata),
    .rvalid(rvalid), .rd_from_latch(rd_from_latch), .slot_start(slot_start),
    .rd_pulse(rd_pulse), .wr_pulse(wr_pulse)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // Caller sits at a negedge on slot tick 0; returns at tick 0 of next slot.
  task automatic run_slot(input bit rd, input bit wr, input logic [10:0] a,
                          input logic [15:0] d, input int g, input int w,
                          input string rq);
    bit hit, exp_rd, exp_wr, is_read, prev_v;
    int tag;
    tag = int'(a >> 3);
    is_read = rd && !wr;
    hit = is_read && ref_valid && (ref_tag == tag);
    prev_v = rvalid;
    chk(slot_start === 1'b1, "R11", "slot_start at tick0", slot_start, 1);
    chk(rd_pulse === 1'b0 && wr_pulse === 1'b0, rq, "pulses idle at tick0",
        {rd_pulse, wr_pulse}, 0);
    rd_en = rd; wr_en = wr; addr = a; wdata = d;
    gap_ticks = 2'(g); wr_width = 2'(w);
    for (int t = 1; t < 10; t++) begin
      @(negedge clk);
      if (t == 1) begin
        rd_en = 1'b0; wr_en = 1'b0; addr = ~a; wdata = ~d;
        gap_ticks = 2'(3 - g); wr_width = 2'(3 - w);   // R11 late change
      end
      exp_rd = (wr || (rd && !hit)) && (t == 1);
      exp_wr = wr && (t >= 2 + g) && (t <= 2 + g + w);
      chk(rd_pulse === exp_rd, rq, $sformatf("rd_pulse tick %0d", t), rd_pulse, exp_rd);
      chk(wr_pulse === exp_wr, rq, $sformatf("wr_pulse tick %0d", t), wr_pulse, exp_wr);
      chk(slot_start === 1'b0, "R11", "slot_start mid slot", slot_start, 0);
      if (t == 5) chk(rvalid === prev_v, "R8", "rvalid held mid slot", rvalid, prev_v);
    end
    @(negedge clk);
    if (wr) begin
      ref_mem[int'(a)] = d; ref_valid = 1; ref_tag = tag;
    end else if (rd && !hit) begin
      ref_valid = 1; ref_tag = tag;
    end
    if (is_read) begin
      chk(rvalid === 1'b1, rq, "rvalid after read", rvalid, 1);
      chk(rd_from_latch === hit, rq, "rd_from_latch", rd_from_latch, hit);
      if (ref_mem.exists(int'(a)))
        chk(rdata === ref_mem[int'(a)], "R2", $sformatf("rdata @%0h", a), rdata, ref_mem[int'(a)]);
    end else begin
      chk(rvalid === 1'b0, rq, "no result without read", rvalid, 0);
    end
  endtask

  // R10: strobes outside tick 0
  task automatic stray_slot(input logic [10:0] a);
    for (int t = 1; t < 10; t++) begin
      @(negedge clk);
      if (t == 3) begin rd_en = 1'b1; wr_en = 1'b1; addr = a; wdata = 16'hDEAD; end
      if (t == 4) begin rd_en = 1'b0; wr_en = 1'b0; end
      chk(rd_pulse === 1'b0 && wr_pulse === 1'b0, "R10", "no pulse from stray strobe",
          {rd_pulse, wr_pulse}, 0);
    end
    @(negedge clk);
    chk(rvalid === 1'b0, "R10", "no result from stray strobe", rvalid, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rd_en = 0; wr_en = 0; addr = '0; wdata = '0;
    gap_ticks = '0; wr_width = '0; ref_valid = 0; ref_tag = -1;
    repeat (4) @(negedge clk);
    chk(rvalid === 1'b0 && rd_from_latch === 1'b0, "R1", "result flags in reset",
        {rvalid, rd_from_latch}, 0);
    chk(rd_pulse === 1'b0 && wr_pulse === 1'b0, "R1", "pulses in reset",
        {rd_pulse, wr_pulse}, 0);
    chk(rdata === 16'h0, "R1", "rdata in reset", rdata, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    while (slot_start !== 1'b1) @(negedge clk);
    chk(rvalid === 1'b0, "R1", "rvalid after release", rvalid, 0);

    // R6: fill bank0 row5 and bank2 row5 with swept margins
    for (int w = 0; w < 8; w++)
      run_slot(0, 1, 11'h028 | 11'(w), 16'hA000 + 16'(w * 16'h111), w % 4, (w / 2) % 4, "R6");
    for (int w = 0; w < 8; w++)
      run_slot(0, 1, 11'h428 | 11'(w), 16'h5000 + 16'(w * 16'h0F1), 3 - (w % 4), w % 4, "R6");

    // R3 / R12: same row index in bank0 after bank2 is a full read
    run_slot(1, 0, 11'h02B, '0, 0, 0, "R12");
    // R4 / R5: other seven words hit the latch
    for (int w = 0; w < 8; w++)
      if (w != 3) run_slot(1, 0, 11'h028 | 11'(w), '0, 0, 0, "R5");
    run_slot(1, 0, 11'h42B, '0, 0, 0, "R3");
    run_slot(1, 0, 11'h42D, '0, 0, 0, "R4");

    // R7: write then read same row from latch
    run_slot(0, 1, 11'h42E, 16'hC0DE, 3, 3, "R7");
    run_slot(1, 0, 11'h42E, '0, 0, 0, "R7");
    run_slot(1, 0, 11'h42F, '0, 0, 0, "R7");

    // R9: read and write together
    run_slot(1, 1, 11'h029, 16'hBEEF, 0, 0, "R9");
    run_slot(1, 0, 11'h029, '0, 0, 0, "R9");
    run_slot(1, 0, 11'h028, '0, 0, 0, "R6");

    // R8: idle slot
    run_slot(0, 0, 11'h000, '0, 1, 1, "R8");

    // R10: stray strobes, then confirm memory and latch unchanged
    stray_slot(11'h02A);
    run_slot(1, 0, 11'h02A, '0, 0, 0, "R10");

    // Unwritten-row miss then back
    run_slot(1, 0, 11'h22A, '0, 0, 0, "R12");
    run_slot(1, 0, 11'h02A, '0, 0, 0, "R3");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule